// File: doc/BRIEF.md
# Audio Stream Descriptor List Walker

This block is the DMA sequencer for one audio stream. On a rising run bit it reads a list of buffer descriptors from memory into local storage. Each descriptor gives a buffer address, a byte length and an interrupt-on-completion flag. A codec transfer request names a stream tag, a direction and a byte count. The walker then splits that request into memory chunks. Each chunk is limited by the bytes still to move, the space left in the cyclic buffer and the bytes left in the current descriptor. It keeps a link position, a descriptor index and an offset within the descriptor, and wraps the position and the index.

When a descriptor marked for interrupt is used up, the walker raises a completion flag at the end of that transfer. It then refuses further transfers until software clears the flag. After each accepted transfer it can store the link position to a write-back slot in memory. A stream reset clears the position state and aborts a transfer in flight. Memory is reached through a single request/acknowledge port, so the block does not care how memory is built.

State machine states are as follows:
- `S_IDLE`: no list is loaded.
- `S_FETCH`: the descriptor list is being read.
- `S_READY`: the block waits for a transfer request.
- `S_MOVE`: one chunk is issued per acknowledge.
- `S_WBACK`: the optional position store.
- `S_DONE`: a one-cycle completion report to the requester.

State transitions are as follows:
- `S_IDLE` to `S_FETCH` on a run rise.
- `S_FETCH` to `S_READY` after the last word is read.
- `S_READY` to `S_MOVE` when a matching transfer is accepted.
- `S_READY` or `S_IDLE` to `S_DONE` when a transfer is rejected.
- `S_MOVE` to `S_WBACK` when no bytes are left or a zero chunk is computed.
- `S_WBACK` to `S_DONE` after the store, or at once if the store is off.
- `S_DONE` back to `S_READY`, or to `S_IDLE` when no list is loaded.
- Any state to `S_IDLE` on stream reset. A busy `S_MOVE` or `S_WBACK` goes through `S_DONE` first.
- `S_READY` to `S_IDLE` when run drops.

Top module: `bdl_walker`

## Requirements
- R1: When run rises (or stream reset is released while run is high), the block reads the list with 4-byte reads (mem_we=0) at list_base + 16*i + 0, + 8 and + 12, for i = 0 up to last_idx, in that order. The word at +0 is the buffer address, the word at +8 the length and the word at +12 the flags.
- R2: The list holds last_idx+1 descriptors. After the last descriptor is used up, the index returns to 0.
- R3: Each data chunk has a length equal to the smallest of three values: the bytes still requested, ring_len minus link_pos, and the descriptor length minus the offset. It is issued at descriptor address plus offset. A chunk of zero bytes is never sent to memory and ends the transfer, so a zero-length request moves nothing and still completes with xfer_ok=1.
- R4: When the offset reaches the descriptor length, the offset returns to 0 and the index advances. If bit 0 of that descriptor's flags word is 1, cmpl_flag is set once the transfer completes.
- R5: link_pos advances by each chunk length and returns to 0 when it reaches ring_len.
- R6: While cmpl_flag is 1, every transfer request completes with xfer_ok=0, moves nothing and issues no memory access. A one-cycle cmpl_clr pulse clears the flag.
- R7: If wb_base bit 0 is 1, each accepted transfer ends with a 4-byte write (mem_we=1) of link_pos to (wb_base with bit 0 cleared) + 8*SLOT. If the bit is 0, no such write happens.
- R8: A request is accepted only if xfer_tag equals stream_tag and xfer_out equals the stream's direction (output when SLOT is 4 or more). Any other request completes with xfer_ok=0 and no memory access.
- R9: While srst is high, link_pos, cur_idx and ent_off are held at 0. A transfer in progress ends with xfer_done and xfer_ok=0, and the list must be read again.
- R10: mem_req stays high with mem_addr unchanged until mem_ack is seen, unless stream reset intervenes.
- R11: Data chunks use mem_we=0 for an output stream and mem_we=1 for an input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Stream run control |
| srst | input | 1 | Stream reset, active high |
| stream_tag | input | TAG_W | Tag this stream answers to |
| list_base | input | ADDR_W | Byte address of descriptor 0 |
| last_idx | input | IDX_W | Index of the last valid descriptor |
| ring_len | input | 32 | Cyclic buffer length in bytes |
| wb_base | input | ADDR_W | Write-back base; bit 0 enables the store |
| cmpl_clr | input | 1 | Clears cmpl_flag |
| xfer_valid | input | 1 | Transfer request, held until xfer_done |
| xfer_tag | input | TAG_W | Tag of the requested transfer |
| xfer_out | input | 1 | 1 = output direction |
| xfer_len | input | XLEN_W | Requested bytes |
| xfer_done | output | 1 | One-cycle completion of a request |
| xfer_ok | output | 1 | Request was accepted and served |
| xfer_moved | output | XLEN_W | Bytes moved by the request |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | ADDR_W | Byte address |
| mem_len | output | XLEN_W | Byte count of the access |
| mem_wdata | output | 32 | Write data (position store) |
| mem_ack | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data (descriptor words) |
| link_pos | output | 32 | Position in the cyclic buffer |
| cur_idx | output | IDX_W | Current descriptor index |
| ent_off | output | 32 | Offset within the current descriptor |
| cmpl_flag | output | 1 | Buffer completion flag |

## Verification
A wrong offset or index shows up on the memory port at the very next chunk, as an address or a length off from the hand-computed value. This happens within the same transfer, or in the first chunk of the next one. A wrong position wrap appears in the chunk length, because the ring remainder bounds it, and in the value of the position store at the end of the transfer. A lost or spurious completion flag appears one cycle after the transfer report, on cmpl_flag. It then changes whether the next request is served or refused.

// File: rtl/bdlw_pkg.sv
package bdlw_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_READY,
        S_MOVE,
        S_WBACK,
        S_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        F_ADDR  = 2'd0,
        F_LEN   = 2'd1,
        F_FLAGS = 2'd2
    } fetch_sel_t;

endpackage

// File: rtl/bdl_table.sv
module bdl_table
    import bdlw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int MAX_ENT = 16,
    parameter int IDX_W   = $clog2(MAX_ENT)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  fetch_sel_t        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_len,
    output logic              rd_ioc
);

    logic [ADDR_W-1:0] addr_q [MAX_ENT];
    logic [WORD_W-1:0] len_q  [MAX_ENT];
    logic              ioc_q  [MAX_ENT];

    for (genvar e = 0; e < MAX_ENT; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q[e] <= '0;
                len_q[e]  <= '0;
                ioc_q[e]  <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                unique case (wr_sel)
                    F_ADDR:  addr_q[e] <= wr_data[ADDR_W-1:0];
                    F_LEN:   len_q[e]  <= wr_data;
                    F_FLAGS: ioc_q[e]  <= wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    assign rd_addr = addr_q[rd_idx];
    assign rd_len  = len_q[rd_idx];
    assign rd_ioc  = ioc_q[rd_idx];

endmodule

// File: rtl/bdl_chunk.sv
module bdl_chunk
    import bdlw_pkg::*;
#(
    parameter int XLEN_W = 16,
    parameter int IDX_W  = 4
)(
    input  logic [XLEN_W-1:0] left,
    input  logic [WORD_W-1:0] pos,
    input  logic [WORD_W-1:0] ring_len,
    input  logic [WORD_W-1:0] off,
    input  logic [WORD_W-1:0] ent_len,
    input  logic              ent_ioc,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  last_idx,
    output logic [XLEN_W-1:0] chunk,
    output logic [WORD_W-1:0] pos_n,
    output logic [WORD_W-1:0] off_n,
    output logic [IDX_W-1:0]  idx_n,
    output logic              irq_hit
);

    logic [WORD_W-1:0] ring_rem;
    logic [WORD_W-1:0] ent_rem;
    logic [WORD_W-1:0] left_ext;
    logic [WORD_W-1:0] step;
    logic [WORD_W-1:0] pos_sum;
    logic [WORD_W-1:0] off_sum;
    logic              ent_fin;

    always_comb begin
        ring_rem = (ring_len > pos) ? (ring_len - pos) : '0;
        ent_rem  = (ent_len > off)  ? (ent_len - off)  : '0;
        left_ext = WORD_W'(left);
        step     = left_ext;
        if (ring_rem < step) step = ring_rem;
        if (ent_rem  < step) step = ent_rem;
        chunk    = step[XLEN_W-1:0];

        pos_sum  = pos + step;
        pos_n    = (pos_sum >= ring_len) ? '0 : pos_sum;

        off_sum  = off + step;
        ent_fin  = (off_sum >= ent_len);
        off_n    = ent_fin ? '0 : off_sum;
        if (!ent_fin)
            idx_n = idx;
        else if (idx >= last_idx)
            idx_n = '0;
        else
            idx_n = idx + IDX_W'(1);
        irq_hit  = ent_fin && ent_ioc;
    end

endmodule

// File: rtl/bdl_walker.sv
module bdl_walker
    import bdlw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int XLEN_W  = 16,
    parameter int MAX_ENT = 16,
    parameter int TAG_W   = 4,
    parameter int SLOT    = 5,
    parameter int IDX_W   = $clog2(MAX_ENT)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              srst,
    input  logic [TAG_W-1:0]  stream_tag,
    input  logic [ADDR_W-1:0] list_base,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [WORD_W-1:0] ring_len,
    input  logic [ADDR_W-1:0] wb_base,
    input  logic              cmpl_clr,
    input  logic              xfer_valid,
    input  logic [TAG_W-1:0]  xfer_tag,
    input  logic              xfer_out,
    input  logic [XLEN_W-1:0] xfer_len,
    output logic              xfer_done,
    output logic              xfer_ok,
    output logic [XLEN_W-1:0] xfer_moved,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [XLEN_W-1:0] mem_len,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] link_pos,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [WORD_W-1:0] ent_off,
    output logic              cmpl_flag
);

    localparam logic              IS_OUT = (SLOT >= 4);
    localparam logic [ADDR_W-1:0] WB_OFF = ADDR_W'(8 * SLOT);
    localparam logic [XLEN_W-1:0] WORD_BYTES = XLEN_W'(4);

    walk_state_t state, state_n;

    logic              run_q;
    logic              list_valid;
    logic [IDX_W-1:0]  fidx;
    fetch_sel_t        fsel;
    logic [WORD_W-1:0] pos;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] off;
    logic [XLEN_W-1:0] left;
    logic [XLEN_W-1:0] moved;
    logic              ok_q;
    logic              irq_pend;
    logic              cmpl;

    logic              run_rise;
    logic              tag_match;
    logic              tbl_we;
    logic [ADDR_W-1:0] ent_addr;
    logic [WORD_W-1:0] ent_len;
    logic              ent_ioc;
    logic [XLEN_W-1:0] chunk;
    logic [WORD_W-1:0] pos_n;
    logic [WORD_W-1:0] off_n;
    logic [IDX_W-1:0]  idx_n;
    logic              irq_hit;
    logic [ADDR_W-1:0] fetch_addr;
    logic [ADDR_W-1:0] wb_addr;
    logic              fetch_last;
    logic              mem_take;

    assign run_rise   = run && !run_q && !srst;
    assign tag_match  = (xfer_tag == stream_tag) && (xfer_out == IS_OUT);
    assign fetch_last = (fsel == F_FLAGS) && (fidx == last_idx);
    assign mem_take   = mem_req && mem_ack;
    assign tbl_we     = (state == S_FETCH) && mem_take;
    assign wb_addr    = {wb_base[ADDR_W-1:1], 1'b0} + WB_OFF;

    always_comb begin
        fetch_addr = list_base + (ADDR_W'(fidx) << 4);
        unique case (fsel)
            F_LEN:   fetch_addr = fetch_addr + ADDR_W'(8);
            F_FLAGS: fetch_addr = fetch_addr + ADDR_W'(12);
            default: ;
        endcase
    end

    bdl_table #(
        .ADDR_W  (ADDR_W),
        .MAX_ENT (MAX_ENT),
        .IDX_W   (IDX_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (fidx),
        .wr_sel  (fsel),
        .wr_data (mem_rdata),
        .rd_idx  (idx),
        .rd_addr (ent_addr),
        .rd_len  (ent_len),
        .rd_ioc  (ent_ioc)
    );

    bdl_chunk #(
        .XLEN_W (XLEN_W),
        .IDX_W  (IDX_W)
    ) u_chunk (
        .left     (left),
        .pos      (pos),
        .ring_len (ring_len),
        .off      (off),
        .ent_len  (ent_len),
        .ent_ioc  (ent_ioc),
        .idx      (idx),
        .last_idx (last_idx),
        .chunk    (chunk),
        .pos_n    (pos_n),
        .off_n    (off_n),
        .idx_n    (idx_n),
        .irq_hit  (irq_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE: begin
                if (srst)            state_n = S_IDLE;
                else if (run_rise)   state_n = S_FETCH;
                else if (xfer_valid) state_n = S_DONE;
            end
            S_FETCH: begin
                if (srst)                        state_n = S_IDLE;
                else if (mem_take && fetch_last) state_n = S_READY;
            end
            S_READY: begin
                if (srst || !run)          state_n = S_IDLE;
                else if (xfer_valid)
                    state_n = (tag_match && !cmpl) ? S_MOVE : S_DONE;
            end
            S_MOVE: begin
                if (srst)                          state_n = S_DONE;
                else if (chunk == '0)              state_n = S_WBACK;
                else if (mem_take && left == chunk) state_n = S_WBACK;
            end
            S_WBACK: begin
                if (srst)                      state_n = S_DONE;
                else if (!wb_base[0] || mem_take) state_n = S_DONE;
            end
            S_DONE: begin
                state_n = (list_valid && !srst) ? S_READY : S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            list_valid <= 1'b0;
            fidx       <= '0;
            fsel       <= F_ADDR;
            pos        <= '0;
            idx        <= '0;
            off        <= '0;
            left       <= '0;
            moved      <= '0;
            ok_q       <= 1'b0;
            irq_pend   <= 1'b0;
            cmpl       <= 1'b0;
        end else begin
            run_q <= srst ? 1'b0 : run;
            if (cmpl_clr) cmpl <= 1'b0;
            if (srst) begin
                pos        <= '0;
                idx        <= '0;
                off        <= '0;
                list_valid <= 1'b0;
                irq_pend   <= 1'b0;
                if (state == S_MOVE || state == S_WBACK) ok_q <= 1'b0;
            end else begin
                unique case (state)
                    S_IDLE: begin
                        if (run_rise) begin
                            fidx <= '0;
                            fsel <= F_ADDR;
                        end else if (xfer_valid) begin
                            ok_q  <= 1'b0;
                            moved <= '0;
                        end
                    end
                    S_FETCH: begin
                        if (mem_take) begin
                            if (fsel == F_FLAGS) begin
                                fsel <= F_ADDR;
                                fidx <= fidx + IDX_W'(1);
                                if (fetch_last) list_valid <= 1'b1;
                            end else if (fsel == F_ADDR) begin
                                fsel <= F_LEN;
                            end else begin
                                fsel <= F_FLAGS;
                            end
                        end
                    end
                    S_READY: begin
                        if (!run) begin
                            list_valid <= 1'b0;
                        end else if (xfer_valid) begin
                            moved    <= '0;
                            irq_pend <= 1'b0;
                            left     <= xfer_len;
                            ok_q     <= tag_match && !cmpl;
                        end
                    end
                    S_MOVE: begin
                        if (chunk == '0 || mem_take) begin
                            pos      <= pos_n;
                            off      <= off_n;
                            idx      <= idx_n;
                            irq_pend <= irq_pend || irq_hit;
                            left     <= left - chunk;
                            moved    <= moved + chunk;
                        end
                    end
                    S_DONE: begin
                        if (ok_q && irq_pend) cmpl <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_len   = '0;
        mem_wdata = '0;
        unique case (state)
            S_FETCH: begin
                mem_req  = !srst;
                mem_addr = fetch_addr;
                mem_len  = WORD_BYTES;
            end
            S_MOVE: begin
                mem_req  = !srst && (chunk != '0);
                mem_we   = !IS_OUT;
                mem_addr = ent_addr + ADDR_W'(off);
                mem_len  = chunk;
            end
            S_WBACK: begin
                mem_req   = !srst && wb_base[0];
                mem_we    = 1'b1;
                mem_addr  = wb_addr;
                mem_len   = WORD_BYTES;
                mem_wdata = pos;
            end
            default: ;
        endcase
    end

    assign xfer_done  = (state == S_DONE);
    assign xfer_ok    = ok_q;
    assign xfer_moved = moved;
    assign link_pos   = pos;
    assign cur_idx    = idx;
    assign ent_off    = off;
    assign cmpl_flag  = cmpl;

    // R3: an issued data chunk is never empty and never exceeds what is left
    a_r3_chunk_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && state == S_MOVE) |-> (mem_len != '0 && mem_len <= left));

    // R2: the index stays inside the loaded list
    a_r2_idx_in_list: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READY && list_valid) |-> (cur_idx <= last_idx));

    // R5: the position is kept below the ring length between transfers
    a_r5_pos_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READY) |-> (ring_len == '0 || link_pos < ring_len));

    // R4: a pending completion becomes visible after the report cycle
    a_r4_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && xfer_ok && irq_pend) |=> cmpl_flag);

    // R6: a flagged stream refuses requests
    a_r6_stall_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READY && cmpl && xfer_valid && run && !srst)
        |=> (xfer_done && !xfer_ok));

    // R9: stream reset clears the walk position
    a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (link_pos == '0 && cur_idx == '0 && ent_off == '0));

    // R10: an unacknowledged request is held with a stable address
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ((mem_req && $stable(mem_addr)) || srst));

endmodule

// File: tb/bdl_walker_bench.sv
`timescale 1ns/1ps
module bdl_walker_bench;

    localparam int ADDR_W = 32;
    localparam int XLEN_W = 16;
    localparam int IDX_W  = 4;
    localparam int TAG_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run = 1'b0;
    logic              srst = 1'b0;
    logic [TAG_W-1:0]  stream_tag = 4'd3;
    logic [ADDR_W-1:0] list_base = 32'h1000;
    logic [IDX_W-1:0]  last_idx = 4'd2;
    logic [31:0]       ring_len = 32'd200;
    logic [ADDR_W-1:0] wb_base = 32'h8001;
    logic              cmpl_clr = 1'b0;
    logic              xfer_valid = 1'b0;
    logic [TAG_W-1:0]  xfer_tag = '0;
    logic              xfer_out = 1'b0;
    logic [XLEN_W-1:0] xfer_len = '0;
    logic              xfer_done;
    logic              xfer_ok;
    logic [XLEN_W-1:0] xfer_moved;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [XLEN_W-1:0] mem_len;
    logic [31:0]       mem_wdata;
    logic              mem_ack = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic [31:0]       link_pos;
    logic [IDX_W-1:0]  cur_idx;
    logic [31:0]       ent_off;
    logic              cmpl_flag;

    bdl_walker u_bdl_walker (
        .clk(clk), .rst_n(rst_n), .run(run), .srst(srst),
        .stream_tag(stream_tag), .list_base(list_base), .last_idx(last_idx),
        .ring_len(ring_len), .wb_base(wb_base), .cmpl_clr(cmpl_clr),
        .xfer_valid(xfer_valid), .xfer_tag(xfer_tag), .xfer_out(xfer_out),
        .xfer_len(xfer_len), .xfer_done(xfer_done), .xfer_ok(xfer_ok),
        .xfer_moved(xfer_moved), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_len(mem_len), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .link_pos(link_pos),
        .cur_idx(cur_idx), .ent_off(ent_off), .cmpl_flag(cmpl_flag)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    logic ack_en = 1'b1;

    logic [31:0] d_addr [3] = '{32'h2000, 32'h3000, 32'h4000};
    logic [31:0] d_len  [3] = '{32'd100, 32'd60, 32'd40};
    logic [31:0] d_flag [3] = '{32'h0, 32'h1, 32'h0};

    int          n_ops = 0;
    logic [31:0] op_addr  [32];
    logic [31:0] op_len   [32];
    logic        op_we    [32];
    logic [31:0] op_wdata [32];

    function automatic logic [31:0] desc_word(input logic [31:0] a);
        logic [31:0] o;
        int i;
        o = a - 32'h1000;
        i = int'(o[7:4]);
        if (i > 2) return 32'h0;
        case (o[3:0])
            4'd0:  return d_addr[i];
            4'd8:  return d_len[i];
            4'd12: return d_flag[i];
            default: return 32'h0;
        endcase
    endfunction

    always @(negedge clk) begin
        cycles++;
        if (mem_req && ack_en) begin
            mem_ack = 1'b1;
            mem_rdata = desc_word(mem_addr);
            if (n_ops < 32) begin
                op_addr[n_ops]  = mem_addr;
                op_len[n_ops]   = 32'(mem_len);
                op_we[n_ops]    = mem_we;
                op_wdata[n_ops] = mem_wdata;
            end
            n_ops++;
        end else begin
            mem_ack = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 100000)", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: act 0x%0h exp 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_xfer(input logic [3:0] tag, input logic out,
                           input logic [15:0] len,
                           output logic ok, output logic [15:0] mv);
        int cnt;
        @(negedge clk);
        n_ops = 0;
        xfer_tag = tag; xfer_out = out; xfer_len = len; xfer_valid = 1'b1;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!xfer_done && cnt < 200);
        ok = xfer_ok;
        mv = xfer_moved;
        xfer_valid = 1'b0;
        check("R6", "transfer reported", 32'(xfer_done), 32'd1);
        @(negedge clk);
    endtask

    task automatic check_op(input string req, input int k, input logic [31:0] a,
                            input logic [31:0] l, input logic we);
        check(req, $sformatf("op%0d addr", k), op_addr[k], a);
        check(req, $sformatf("op%0d len", k), op_len[k], l);
        check("R11", $sformatf("op%0d we", k), 32'(op_we[k]), 32'(we));
    endtask

    task automatic t_reset;
        check("R9", "reset link_pos", link_pos, 0);
        check("R9", "reset cur_idx", 32'(cur_idx), 0);
        check("R9", "reset ent_off", ent_off, 0);
        check("R6", "reset cmpl_flag", 32'(cmpl_flag), 0);
        check("R10", "reset mem_req", 32'(mem_req), 0);
    endtask

    task automatic check_fetch;
        check("R1", "fetch read count", 32'(n_ops), 9);
        for (int k = 0; k < 9; k++) begin
            logic [31:0] e;
            e = 32'h1000 + 32'(16 * (k / 3)) + ((k % 3 == 0) ? 32'd0 : (k % 3 == 1) ? 32'd8 : 32'd12);
            check("R1", $sformatf("fetch%0d addr", k), op_addr[k], e);
            check("R1", $sformatf("fetch%0d we", k), 32'(op_we[k]), 0);
        end
    endtask

    task automatic t_fetch;
        @(negedge clk);
        n_ops = 0;
        run = 1'b1;
        repeat (20) @(negedge clk);
        check_fetch();
    endtask

    task automatic t_first;
        logic ok; logic [15:0] mv;
        do_xfer(4'd3, 1'b1, 16'd70, ok, mv);
        check("R3", "first ok", 32'(ok), 1);
        check("R3", "first moved", 32'(mv), 70);
        check("R3", "first op count", 32'(n_ops), 2);
        check_op("R3", 0, 32'h2000, 70, 1'b0);
        check_op("R7", 1, 32'h8028, 4, 1'b1);
        check("R7", "first store data", op_wdata[1], 70);
        check("R5", "first pos", link_pos, 70);
    endtask

    task automatic t_cross_entry;
        logic ok; logic [15:0] mv;
        do_xfer(4'd3, 1'b1, 16'd50, ok, mv);
        check("R3", "cross op count", 32'(n_ops), 3);
        check_op("R3", 0, 32'h2046, 30, 1'b0);
        check_op("R4", 1, 32'h3000, 20, 1'b0);
        check("R4", "cross idx", 32'(cur_idx), 1);
        check("R4", "cross off", ent_off, 20);
        check("R7", "cross store data", op_wdata[2], 120);
        check("R4", "no flag yet", 32'(cmpl_flag), 0);
    endtask

    task automatic t_flag_set;
        logic ok; logic [15:0] mv;
        do_xfer(4'd3, 1'b1, 16'd60, ok, mv);
        check("R4", "flag op count", 32'(n_ops), 3);
        check_op("R4", 0, 32'h3014, 40, 1'b0);
        check_op("R3", 1, 32'h4000, 20, 1'b0);
        check("R4", "flag raised", 32'(cmpl_flag), 1);
        check("R5", "flag pos", link_pos, 180);
        check("R4", "flag idx", 32'(cur_idx), 2);
    endtask

    task automatic t_stall_clear;
        logic ok; logic [15:0] mv;
        do_xfer(4'd3, 1'b1, 16'd10, ok, mv);
        check("R6", "stalled ok", 32'(ok), 0);
        check("R6", "stalled ops", 32'(n_ops), 0);
        check("R6", "stalled pos", link_pos, 180);
        cmpl_clr = 1'b1;
        @(negedge clk);
        cmpl_clr = 1'b0;
        check("R6", "flag cleared", 32'(cmpl_flag), 0);
    endtask

    task automatic t_wrap;
        logic ok; logic [15:0] mv;
        do_xfer(4'd3, 1'b1, 16'd50, ok, mv);
        check("R2", "wrap op count", 32'(n_ops), 3);
        check_op("R5", 0, 32'h4014, 20, 1'b0);
        check_op("R2", 1, 32'h2000, 30, 1'b0);
        check("R7", "wrap store data", op_wdata[2], 30);
        check("R2", "wrap idx", 32'(cur_idx), 0);
        check("R5", "wrap pos", link_pos, 30);
        check("R4", "no flag on plain entry", 32'(cmpl_flag), 0);
    endtask

    task automatic t_zero_len;
        logic ok; logic [15:0] mv;
        do_xfer(4'd3, 1'b1, 16'd0, ok, mv);
        check("R3", "zero ok", 32'(ok), 1);
        check("R3", "zero moved", 32'(mv), 0);
        check("R3", "zero ops", 32'(n_ops), 1);
        check("R7", "zero store addr", op_addr[0], 32'h8028);
        check("R7", "zero store data", op_wdata[0], 30);
    endtask

    task automatic t_mismatch;
        logic ok; logic [15:0] mv;
        do_xfer(4'd4, 1'b1, 16'd10, ok, mv);
        check("R8", "wrong tag ok", 32'(ok), 0);
        check("R8", "wrong tag ops", 32'(n_ops), 0);
        do_xfer(4'd3, 1'b0, 16'd10, ok, mv);
        check("R8", "wrong dir ok", 32'(ok), 0);
        check("R8", "wrong dir ops", 32'(n_ops), 0);
        check("R8", "pos untouched", link_pos, 30);
    endtask

    task automatic t_wb_disabled;
        logic ok; logic [15:0] mv;
        wb_base = 32'h8000;
        do_xfer(4'd3, 1'b1, 16'd5, ok, mv);
        check("R7", "no store ops", 32'(n_ops), 1);
        check_op("R3", 0, 32'h201E, 5, 1'b0);
        check("R5", "pos after 5", link_pos, 35);
        wb_base = 32'h8001;
    endtask

    task automatic t_abort;
        @(negedge clk);
        ack_en = 1'b0;
        xfer_tag = 4'd3; xfer_out = 1'b1; xfer_len = 16'd40; xfer_valid = 1'b1;
        repeat (2) @(negedge clk);
        check("R10", "held req", 32'(mem_req), 1);
        check("R10", "held addr", mem_addr, 32'h2023);
        @(negedge clk);
        check("R10", "still held", 32'(mem_req), 1);
        check("R3", "held len", 32'(mem_len), 40);
        srst = 1'b1;
        @(negedge clk);
        check("R9", "abort done", 32'(xfer_done), 1);
        check("R9", "abort ok", 32'(xfer_ok), 0);
        xfer_valid = 1'b0;
        @(negedge clk);
        check("R9", "abort pos", link_pos, 0);
        check("R9", "abort idx", 32'(cur_idx), 0);
        check("R9", "abort off", ent_off, 0);
        ack_en = 1'b1;
        n_ops = 0;
        srst = 1'b0;
        repeat (20) @(negedge clk);
        check_fetch();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fetch();
        t_first();
        t_cross_entry();
        t_flag_set();
        t_stall_clear();
        t_wrap();
        t_zero_len();
        t_mismatch();
        t_wb_disabled();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule